// File: doc/BRIEF.md
# Programmable ADC Sample Sequencer

This block walks an external analog-to-digital converter through a programmed list of up to eight conversion slots. Every slot holds an input-select code and a 4-bit control nibble. For the current slot the block drives a channel-select output, a differential flag and a one-cycle conversion-start strobe. When the converter reports done, the block captures the result and offers it on a valid/ready result-write port, tagged with the slot index. It then moves to the next slot, or stops after the slot marked as last.

A run starts from a software initiate strobe, and only while the enable input is high. Configuration is expected to be written while the block is disabled. Several sequencers can also be started in the same cycle. In that mode each one holds its initiate request while the shared hold input is high, and a shared sync strobe then launches all of the held sequencers together. A slot whose interrupt flag is set raises a one-cycle pulse on its own interrupt line when its result is accepted.

The result port follows valid/ready rules. Once `res_valid` rises, `res_data` and `res_slot` stay unchanged until the cycle in which `res_ready` is also high. The block does not start the next conversion until that transfer has completed. This means a slow consumer stretches the run but never loses a sample.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset `busy`, `conv_start`, `res_valid` and every bit of `irq_pulse` are low.
- R2: While `seq_en` is low, a `sw_start` strobe produces no `conv_start`.
- R3: With `seq_en` high and `sync_hold` low, a `sw_start` seen at a clock edge starts the run: `conv_start` is high in the following cycle for slot 0, and `busy` is high from that cycle until the final result is accepted.
- R4: Slots run in ascending order from 0, and the same select code may appear in several slots. During each slot `conv_sel` carries the slot's code, taken from bits [4k+3:4k] of `cfg_sel`. Each conversion gives exactly one result transfer, whose `res_data` is the `conv_data` value present with `conv_done` and whose `res_slot` is k. After the transfer for a slot that is not the last, `conv_start` for the next slot follows in the next cycle.
- R5: Control nibble bit 1 of slot k (`cfg_ctl[4k+1]`) marks it as last, and the run ends after its result is accepted. If no slot is marked, the run ends after slot 7. `busy` is low in the cycle after the final transfer.
- R6: Control nibble bit 2 (interrupt enable) of slot k makes `irq_pulse[k]` high, alone and for one cycle, exactly in the cycle in which that slot's result transfer completes. Slots without the bit give no pulse.
- R7: Control nibble bit 3 (temperature sensor) replaces `conv_sel` with the parameter `TEMP_CODE` (default 4'hF) for that slot. Control nibble bit 0 (differential) drives `conv_diff` high for that slot.
- R8: A `sw_start` that arrives while `busy` is high is ignored. This includes the cycle of the final result transfer, so no `conv_start` follows.
- R9: If `sw_start` arrives while `sync_hold` is high and the block is enabled and idle, the request is held and no `conv_start` occurs. A later `sync_go` launches the run, with `conv_start` in the next cycle. A `sync_go` with no held request does nothing. A held request is dropped when `seq_en` goes low.
- R10: While `res_valid` is high and `res_ready` is low, `res_valid`, `res_data` and `res_slot` hold their values and no `conv_start` occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seq_en | input | 1 | Sequencer enable |
| cfg_sel | input | 32 | Select code per slot, 4 bits per slot, slot 0 in the low bits |
| cfg_ctl | input | 32 | Control nibble per slot: bit0 diff, bit1 last, bit2 irq enable, bit3 temp |
| sw_start | input | 1 | Software initiate strobe |
| sync_hold | input | 1 | Hold initiate requests for a group start |
| sync_go | input | 1 | Group start strobe that releases a held request |
| conv_start | output | 1 | One-cycle conversion-start strobe |
| conv_sel | output | 4 | Channel select for the current slot |
| conv_diff | output | 1 | Differential mode for the current slot |
| conv_done | input | 1 | Converter reports that its result is ready |
| conv_data | input | 12 | Converter result |
| res_valid | output | 1 | Result-write valid |
| res_ready | input | 1 | Result-write ready |
| res_data | output | 12 | Result value |
| res_slot | output | 3 | Slot index of the result |
| irq_pulse | output | 8 | Per-slot interrupt pulses |
| busy | output | 1 | A sequence is running |

## Verification
Two things can fall in the same cycle here: the accepted transfer of the final slot's result, and a fresh `sw_start` strobe. At that instant the block is still busy, but it goes idle at the very next edge. The bench drives `sw_start` together with `res_ready` on the last slot of every run. It then checks that `busy` drops and that no `conv_start` appears over the next few cycles, while the slot's interrupt pulse is still seen in the transfer cycle. The sweep covers every position of the last-slot mark, plus the unmarked case, in both the direct and the held-then-synced start modes, with converter latency and result back-pressure varying from slot to slot.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CTL_W    = 4;
  localparam int CTL_DIFF = 0;
  localparam int CTL_LAST = 1;
  localparam int CTL_IE   = 2;
  localparam int CTL_TEMP = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_WRITE
  } seq_state_t;
endpackage

// File: rtl/seq_trigger.sv
module seq_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic idle,
  input  logic sw_start,
  input  logic sync_hold,
  input  logic sync_go,
  output logic launch
);
  logic pend_q;

  assign launch = idle && en && ((sw_start && !sync_hold) || (sync_go && pend_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          pend_q <= 1'b0;
    else if (!en || launch)              pend_q <= 1'b0;
    else if (idle && sw_start && sync_hold) pend_q <= 1'b1;
  end

  // R9
  held_no_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_start && sync_hold && !pend_q) |-> !launch);

  // R2
  disabled_no_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !launch);
endmodule

// File: rtl/seq_slot_decode.sv
module seq_slot_decode #(
  parameter int NSLOT     = 8,
  parameter int SELW      = 4,
  parameter logic [SELW-1:0] TEMP_CODE = '1,
  localparam int CW  = adc_seq_pkg::CTL_W,
  localparam int SLW = $clog2(NSLOT)
) (
  input  logic [NSLOT*SELW-1:0] cfg_sel,
  input  logic [NSLOT*CW-1:0]   cfg_ctl,
  input  logic [SLW-1:0]        slot,
  output logic [SELW-1:0]       sel,
  output logic                  diff,
  output logic                  last,
  output logic                  ie
);
  import adc_seq_pkg::*;

  logic [SELW-1:0] sel_a [NSLOT];
  logic [CW-1:0]   ctl_a [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_unpack
    assign sel_a[g] = cfg_sel[g*SELW +: SELW];
    assign ctl_a[g] = cfg_ctl[g*CW +: CW];
  end

  logic [CW-1:0] ctl_cur;
  assign ctl_cur = ctl_a[slot];

  always_comb begin
    sel  = ctl_cur[CTL_TEMP] ? TEMP_CODE : sel_a[slot];
    diff = ctl_cur[CTL_DIFF];
    ie   = ctl_cur[CTL_IE];
    last = ctl_cur[CTL_LAST] || (slot == SLW'(NSLOT-1));
  end
endmodule

// File: rtl/seq_result_stage.sv
module seq_result_stage #(
  parameter int NSLOT = 8,
  parameter int DATW  = 12,
  localparam int SLW  = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [DATW-1:0]  data_in,
  input  logic [SLW-1:0]   slot_in,
  input  logic             ie_in,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [DATW-1:0]  res_data,
  output logic [SLW-1:0]   res_slot,
  output logic             accept,
  output logic [NSLOT-1:0] irq_pulse
);
  logic ie_q;

  assign accept = res_valid && res_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_slot  <= '0;
      ie_q      <= 1'b0;
    end else if (capture) begin
      res_valid <= 1'b1;
      res_data  <= data_in;
      res_slot  <= slot_in;
      ie_q      <= ie_in;
    end else if (accept) begin
      res_valid <= 1'b0;
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_irq
    assign irq_pulse[g] = accept && ie_q && (res_slot == SLW'(g));
  end

  // R10
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_slot)));

  // R6
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_pulse));

  // R6
  irq_on_transfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_pulse) |-> (res_valid && res_ready));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int NSLOT = 8,
  parameter int SELW  = 4,
  parameter int DATW  = 12,
  parameter logic [SELW-1:0] TEMP_CODE = '1,
  localparam int CW  = adc_seq_pkg::CTL_W,
  localparam int SLW = $clog2(NSLOT)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  seq_en,
  input  logic [NSLOT*SELW-1:0] cfg_sel,
  input  logic [NSLOT*CW-1:0]   cfg_ctl,
  input  logic                  sw_start,
  input  logic                  sync_hold,
  input  logic                  sync_go,
  output logic                  conv_start,
  output logic [SELW-1:0]       conv_sel,
  output logic                  conv_diff,
  input  logic                  conv_done,
  input  logic [DATW-1:0]       conv_data,
  output logic                  res_valid,
  input  logic                  res_ready,
  output logic [DATW-1:0]       res_data,
  output logic [SLW-1:0]        res_slot,
  output logic [NSLOT-1:0]      irq_pulse,
  output logic                  busy
);
  import adc_seq_pkg::*;

  seq_state_t     state_q, state_d;
  logic [SLW-1:0] slot_q, slot_d;
  logic           launch, accept, capture;
  logic           cur_last, cur_ie;

  seq_trigger u_trig (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (seq_en),
    .idle      (state_q == ST_IDLE),
    .sw_start  (sw_start),
    .sync_hold (sync_hold),
    .sync_go   (sync_go),
    .launch    (launch)
  );

  seq_slot_decode #(
    .NSLOT     (NSLOT),
    .SELW      (SELW),
    .TEMP_CODE (TEMP_CODE)
  ) u_dec (
    .cfg_sel (cfg_sel),
    .cfg_ctl (cfg_ctl),
    .slot    (slot_q),
    .sel     (conv_sel),
    .diff    (conv_diff),
    .last    (cur_last),
    .ie      (cur_ie)
  );

  assign capture = (state_q == ST_WAIT) && conv_done;

  seq_result_stage #(
    .NSLOT (NSLOT),
    .DATW  (DATW)
  ) u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (capture),
    .data_in   (conv_data),
    .slot_in   (slot_q),
    .ie_in     (cur_ie),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .res_data  (res_data),
    .res_slot  (res_slot),
    .accept    (accept),
    .irq_pulse (irq_pulse)
  );

  always_comb begin
    state_d = state_q;
    slot_d  = slot_q;
    unique case (state_q)
      ST_IDLE:  if (launch) begin state_d = ST_ISSUE; slot_d = '0; end
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT:  if (conv_done) state_d = ST_WRITE;
      ST_WRITE: if (accept) begin
                  if (cur_last) state_d = ST_IDLE;
                  else begin state_d = ST_ISSUE; slot_d = slot_q + 1'b1; end
                end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
    end
  end

  assign conv_start = (state_q == ST_ISSUE);
  assign busy       = (state_q != ST_IDLE);

  // R3
  start_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy);

  // R4
  start_is_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R5
  end_after_transfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(res_valid && res_ready));

  // R10
  no_start_in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> !conv_start);
endmodule

// File: tb/adc_seq_ctrl_test.sv
`timescale 1ns/1ps
module adc_seq_ctrl_test;
  localparam int NS = 8;
  localparam logic [3:0] TCODE = 4'hF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seq_en = 1'b0;
  logic [31:0] cfg_sel = '0;
  logic [31:0] cfg_ctl = '0;
  logic        sw_start = 1'b0, sync_hold = 1'b0, sync_go = 1'b0;
  logic        conv_start, conv_diff, conv_done = 1'b0;
  logic [3:0]  conv_sel;
  logic [11:0] conv_data = '0;
  logic        res_valid, res_ready = 1'b0;
  logic [11:0] res_data;
  logic [2:0]  res_slot;
  logic [7:0]  irq_pulse;
  logic        busy;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  adc_seq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .seq_en(seq_en), .cfg_sel(cfg_sel), .cfg_ctl(cfg_ctl),
    .sw_start(sw_start), .sync_hold(sync_hold), .sync_go(sync_go),
    .conv_start(conv_start), .conv_sel(conv_sel), .conv_diff(conv_diff),
    .conv_done(conv_done), .conv_data(conv_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .res_slot(res_slot), .irq_pulse(irq_pulse), .busy(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One full run; endpos 8 means no slot carries the last mark; mode 1 uses hold + sync_go.
  task automatic run_seq(input int endpos, input int mode, input int seed);
    logic [3:0] sel_a [NS];
    logic [3:0] ctl_a [NS];
    int nslots;
    logic [7:0] iemask;
    iemask = 8'hA5 ^ 8'(endpos * 29 + mode * 3);
    for (int k = 0; k < NS; k++) begin
      sel_a[k] = 4'((k * 3 + seed) % 5);
      ctl_a[k] = {((k + seed) % 4 == 1) ? 1'b1 : 1'b0, iemask[k],
                  (k == endpos) ? 1'b1 : 1'b0, ((k + seed) % 3 == 0) ? 1'b1 : 1'b0};
      cfg_sel[k*4 +: 4] = sel_a[k];
      cfg_ctl[k*4 +: 4] = ctl_a[k];
    end
    nslots = (endpos < NS) ? endpos + 1 : NS;
    seq_en = 1'b1;
    @(negedge clk);
    if (mode == 1) begin
      sync_hold = 1'b1; sw_start = 1'b1;
      @(negedge clk); sw_start = 1'b0;
      for (int i = 0; i < 3; i++) begin
        chk("R9 held request no start", conv_start, 0);
        @(negedge clk);
      end
      sync_go = 1'b1;
      @(negedge clk); sync_go = 1'b0; sync_hold = 1'b0;
    end else begin
      sw_start = 1'b1;
      @(negedge clk); sw_start = 1'b0;
    end
    chk("R3 busy at first start", busy, 1);
    for (int k = 0; k < nslots; k++) begin
      logic [11:0] dval;
      int lat, stall;
      dval = 12'((k * 37 + seed * 5 + endpos * 101) & 12'hFFF);
      lat = (k + seed) % 3;
      stall = (k + endpos) % 3;
      chk("R4 conv_start per slot", conv_start, 1);
      chk("R4/R7 conv_sel", conv_sel, ctl_a[k][3] ? TCODE : sel_a[k]);
      chk("R7 conv_diff", conv_diff, ctl_a[k][0]);
      @(negedge clk);
      for (int i = 0; i < lat; i++) @(negedge clk);
      conv_done = 1'b1; conv_data = dval;
      @(negedge clk);
      conv_done = 1'b0; conv_data = '0;
      chk("R4 res_valid after done", res_valid, 1);
      for (int i = 0; i < stall; i++) begin
        chk("R10 stalled data held", res_data, dval);
        chk("R10 no start during stall", conv_start, 0);
        @(negedge clk);
        chk("R10 valid held", res_valid, 1);
      end
      chk("R4 res_data", res_data, dval);
      chk("R4 res_slot", res_slot, k);
      res_ready = 1'b1;
      if (k == nslots - 1) sw_start = 1'b1;
      #1;
      chk("R6 irq pulse", irq_pulse, iemask[k] ? (8'h1 << k) : 8'h0);
      @(negedge clk);
      res_ready = 1'b0; sw_start = 1'b0;
      chk("R6 irq one cycle", irq_pulse, 0);
    end
    chk("R5 busy low after last", busy, 0);
    for (int i = 0; i < 3; i++) begin
      chk("R8 start in final cycle ignored", conv_start, 0);
      @(negedge clk);
    end
    chk("R5 no extra result", res_valid, 0);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 conv_start", conv_start, 0);
    chk("R1 res_valid", res_valid, 0);
    chk("R1 irq_pulse", irq_pulse, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: disabled start
    sw_start = 1'b1;
    @(negedge clk); sw_start = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk("R2 disabled no start", conv_start, 0);
      chk("R2 disabled not busy", busy, 0);
      @(negedge clk);
    end
    // R9: sync_go with nothing held
    seq_en = 1'b1;
    sync_go = 1'b1;
    @(negedge clk); sync_go = 1'b0;
    chk("R9 bare sync_go ignored", conv_start, 0);
    // R9: held request dropped by disable
    sync_hold = 1'b1; sw_start = 1'b1;
    @(negedge clk); sw_start = 1'b0; seq_en = 1'b0;
    @(negedge clk); seq_en = 1'b1;
    @(negedge clk); sync_go = 1'b1;
    @(negedge clk); sync_go = 1'b0; sync_hold = 1'b0;
    chk("R9 dropped request", conv_start, 0);
    // Sweep last-slot position and start mode
    for (int m = 0; m < 2; m++)
      for (int e = 0; e <= NS; e++)
        run_seq(e, m, e + m * 2);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule